// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B, through a path of configurable width. It has one storage register for each side. Either bus can be driven with the live value present on the opposite bus or with the snapshot held in the opposite side's register. One active-low enable and one direction input pick which bus, if any, the block drives. A separate source select for each direction picks live or stored data. Each bus is presented as three ports: an input, an output and an output enable. A pad ring or an on-chip bus fabric can then resolve the three-state pin outside this module.

Each capture strobe is sampled by the system clock. A rising edge of a strobe loads that side's register from its own bus input. This happens whatever the enable, direction and select inputs are doing. Both output data and output enables come from flip-flops, so a change of select or enable reaches the pins on a clock edge as a clean switch.

Top module: `regbus_xcvr`

## Requirements
- R1: When `oe_n` is 1 at a clock edge, both `a_oe` and `b_oe` are 0 and both `a_out` and `b_out` are all zeros after that edge.
- R2: When `oe_n` is 0 at an edge, `dir` = 0 makes `a_oe` 1 and `b_oe` 0 after that edge, and `dir` = 1 makes `b_oe` 1 and `a_oe` 0. The output of the undriven side reads zero.
- R3: A select input at 0 (`sel_b2a` for bus A, `sel_a2b` for bus B) makes the driven output equal the opposite bus input sampled at the same edge, one cycle of latency.
- R4: A select input at 1 makes the driven output equal the opposite side's register contents as they stood before that edge. A capture at the same edge shows only one cycle later.
- R5: A register captures its own bus input at an edge where its strobe is 1 and was 0 at the previous edge. This holds whatever `oe_n`, `dir` and the selects are.
- R6: A strobe held at 1 or held at 0 causes no capture, and the register keeps its value.
- R7: Both registers may capture at the same edge, including while the buses are isolated.
- R8: Synchronous active-high `rst` clears both registers to zero, deasserts both output enables and zeroes both outputs. A strobe that is high when reset ends does not count as a rising edge until it has gone low and back high.
- R9: `a_oe` and `b_oe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Active-low enable for both bus drivers |
| dir | input | 1 | 0: drive bus A, 1: drive bus B |
| cap_a | input | 1 | Capture strobe for the side-A register |
| cap_b | input | 1 | Capture strobe for the side-B register |
| sel_a2b | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_b2a | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | DATA_W | Value seen on bus A pins |
| a_out | output | DATA_W | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | DATA_W | Value seen on bus B pins |
| b_out | output | DATA_W | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds the block at its default width of eight bits. With that width, distinct byte patterns on each bus show at once whether an output carries live data, a fresh snapshot or a stale one. The stimulus table places a capture and a stored-data read on the same edge, so the one-cycle ordering between a register load and its appearance on the far bus is observed. Directed steps apply reset with a strobe held high and then release it, which reaches the case where a level that is already high must not be taken as an edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

    // A side is driven when the block is enabled and the direction points at it.
    function automatic logic side_driven(input logic en_n, input logic direction,
                                         input side_e side);
        return !en_n && (direction == logic'(side));
    endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    // Reset seeds the history high so a level already high is not an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe;
    end

    assign rise = strobe && !prev_q;

endmodule

// File: rtl/xcvr_snapshot.sv
module xcvr_snapshot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= din;
    end

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        capture |=> q == $past(din));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(q));

    assert_clear_R8: assert property (@(posedge clk)
        rst |=> q == '0);

endmodule

// File: rtl/xcvr_out_stage.sv
module xcvr_out_stage
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              sel,
    input  logic [DATA_W-1:0] live,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    src_sel_e              src;
    logic [DATA_W-1:0]     pick;

    assign src = src_sel_e'(sel);

    always_comb begin
        unique case (src)
            SRC_STORED: pick = stored;
            default:    pick = live;
        endcase
    end

    // Registered so a select or enable change lands as one clean step.
    always_ff @(posedge clk) begin
        if (rst) begin
            oe   <= 1'b0;
            dout <= '0;
        end else begin
            oe   <= enable;
            dout <= enable ? pick : '0;
        end
    end

    assert_live_path_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && !sel) |=> dout == $past(live));

    assert_stored_path_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && sel) |=> dout == $past(stored));

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!oe && dout == '0));

    assert_reset_off_R8: assert property (@(posedge clk)
        rst |=> (!oe && dout == '0));

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic              dir,
    input  logic              cap_a,
    input  logic              cap_b,
    input  logic              sel_a2b,
    input  logic              sel_b2a,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe
);
    localparam int LAST = NUM_SIDES - 1;

    logic [DATA_W-1:0] bus_in  [NUM_SIDES];
    logic [DATA_W-1:0] snap    [NUM_SIDES];
    logic [DATA_W-1:0] drv     [NUM_SIDES];
    logic [LAST:0]     strobe;
    logic [LAST:0]     rise;
    logic [LAST:0]     src_sel;
    logic [LAST:0]     drv_oe;

    assign bus_in[SIDE_A] = a_in;
    assign bus_in[SIDE_B] = b_in;
    assign strobe  = {cap_b, cap_a};
    // Select for the output of side g: A takes stored-B choice, B takes stored-A.
    assign src_sel = {sel_a2b, sel_b2a};

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        localparam int OTHER = LAST - g;

        xcvr_strobe_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .strobe (strobe[g]),
            .rise   (rise[g])
        );

        xcvr_snapshot #(.DATA_W(DATA_W)) u_snap (
            .clk     (clk),
            .rst     (rst),
            .capture (rise[g]),
            .din     (bus_in[g]),
            .q       (snap[g])
        );

        xcvr_out_stage #(.DATA_W(DATA_W)) u_out (
            .clk    (clk),
            .rst    (rst),
            .enable (side_driven(oe_n, dir, side_e'(g))),
            .sel    (src_sel[g]),
            .live   (bus_in[OTHER]),
            .stored (snap[OTHER]),
            .dout   (drv[g]),
            .oe     (drv_oe[g])
        );
    end

    assign a_out = drv[SIDE_A];
    assign b_out = drv[SIDE_B];
    assign a_oe  = drv_oe[SIDE_A];
    assign b_oe  = drv_oe[SIDE_B];

    assert_isolate_R1: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> (!a_oe && !b_oe));

    assert_dir_picks_side_R2: assert property (@(posedge clk) disable iff (rst)
        !oe_n |=> (a_oe == !$past(dir) && b_oe == $past(dir)));

    assert_single_driver_R9: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));

    assert_dual_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (rise[SIDE_A] && rise[SIDE_B]) |=>
            (snap[SIDE_A] == $past(a_in) && snap[SIDE_B] == $past(b_in)));

endmodule

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;

    localparam int W = 8;
    localparam int NVEC = 12;

    logic         clk = 1'b0;
    logic         rst;
    logic         oe_n, dir, cap_a, cap_b, sel_a2b, sel_b2a;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    regbus_xcvr #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
        .cap_a(cap_a), .cap_b(cap_b), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // {oe_n, dir, sel_a2b, sel_b2a, cap_a, cap_b, a_in, b_in, a_oe, b_oe, a_out, b_out}
    localparam logic [39:0] VEC [NVEC] = '{
        {6'b100000, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},
        {6'b100011, 8'h3C, 8'h5A, 2'b00, 8'h00, 8'h00},
        {6'b000011, 8'h77, 8'h88, 2'b10, 8'h88, 8'h00},
        {6'b000100, 8'h99, 8'h66, 2'b10, 8'h5A, 8'h00},
        {6'b011100, 8'h12, 8'h34, 2'b01, 8'h00, 8'h3C},
        {6'b010000, 8'hF0, 8'h0F, 2'b01, 8'h00, 8'hF0},
        {6'b011010, 8'hAB, 8'hCD, 2'b01, 8'h00, 8'h3C},
        {6'b011000, 8'h00, 8'h00, 2'b01, 8'h00, 8'hAB},
        {6'b000101, 8'h00, 8'hE1, 2'b10, 8'h5A, 8'h00},
        {6'b000100, 8'h00, 8'h00, 2'b10, 8'hE1, 8'h00},
        {6'b100100, 8'h00, 8'h00, 2'b00, 8'h00, 8'h00},
        {6'b011000, 8'h00, 8'h00, 2'b01, 8'h00, 8'hAB}
    };

    function automatic string tag_of(input int k);
        case (k)
            0, 10:   return "R1 isolation";
            1:       return "R7 dual capture while isolated";
            2:       return "R6 held strobes, R3 live B to A";
            3:       return "R4 stored B to A";
            4:       return "R2 direction to B, R4";
            5:       return "R3 live A to B";
            6:       return "R5 capture shows old value";
            7:       return "R5 new value after capture";
            8:       return "R5 capture B while driving A";
            9:       return "R4 fresh B snapshot";
            default: return "R2 R9 single side enabled";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W+W+1:0] act,
                         input logic [W+W+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got oe=%b a=%h b=%h, expected oe=%b a=%h b=%h",
                     tag, act[W+W+1:W+W], act[W+W-1:W], act[W-1:0],
                     exp[W+W+1:W+W], exp[W+W-1:W], exp[W-1:0]);
        end
    endtask

    task automatic drive(input logic [5:0] ctl, input logic [W-1:0] av,
                         input logic [W-1:0] bv);
        {oe_n, dir, sel_a2b, sel_b2a, cap_a, cap_b} = ctl;
        a_in = av;
        b_in = bv;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, R1..R9 incomplete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(6'b100000, '0, '0);
        repeat (3) @(negedge clk);
        check("R8 reset state", {a_oe, b_oe, a_out, b_out}, '0);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][39:34], VEC[k][33:26], VEC[k][25:18]);
            step();
            check(tag_of(k), {a_oe, b_oe, a_out, b_out}, VEC[k][17:0]);
            if (a_oe && b_oe) begin
                checks++;
                errors++;
                $display("FAIL R9: both enables high, got 11 expected not 11");
            end
        end

        // Reset in the middle of activity with a strobe held high (R8).
        drive(6'b011010, 8'h42, 8'h24);
        rst = 1'b1;
        step();
        check("R8 reset clears outputs", {a_oe, b_oe, a_out, b_out}, '0);
        rst = 1'b0;
        // Strobe still high after reset: no capture, register A reads zero (R8, R6).
        step();
        check("R8 high strobe at reset release", {a_oe, b_oe, a_out, b_out},
              {2'b01, 8'h00, 8'h00});
        step();
        check("R6 held strobe still no capture", {a_oe, b_oe, a_out, b_out},
              {2'b01, 8'h00, 8'h00});
        drive(6'b011000, 8'h5C, 8'h00);
        step();
        drive(6'b011010, 8'h5C, 8'h00);
        step();
        check("R5 rising edge shows old value", {a_oe, b_oe, a_out, b_out},
              {2'b01, 8'h00, 8'h00});
        drive(6'b011010, 8'h00, 8'h00);
        step();
        check("R5 captured value after edge", {a_oe, b_oe, a_out, b_out},
              {2'b01, 8'h00, 8'h5C});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule